// File: doc/BRIEF.md
# Two-Channel Short Pulse Suppressor

This block cleans the two switching command inputs of a half-bridge gate driver, one for the upper switch and one for the lower switch. Each asynchronous input first passes through a two-flop synchroniser. A per-channel persistence counter then accepts a new level only after it has held for a whole suppression window. A fixed delay line follows, so that the time from input edge to output edge is the same for every edge. Noise spikes and pulses shorter than the window never reach the gate outputs. Rising and falling edges are treated alike, and the two channels are fully independent.

A mode input chooses between two timing sets. The long set is the precise digital filter: with the 12.5 ns clock the defaults assume, it gives a window of about 390 ns and a total latency of about 830 ns. The short set stands in for a fast analog filter, with a window of about 200 ns and a latency of about 500 ns. The mode is captured during reset and then held. Every window and latency is a parameter counted in clock cycles. The uncertainty in latency is one clock period, because the input is sampled once per clock.

Top module: `spf_two_ch`

## Requirements
- R1: While rst_ni is low, both top_on_o and bot_on_o are low. They remain low on the first clock edge after reset is released.
- R2: A high input level is an on command and a low level is an off command. Each output equals the persisted level of its own input, delayed by the mode's latency.
- R3: In long mode (filt_dig_i high at reset), any level held for fewer than DIG_WIN consecutive clock samples (default 31) never changes the output.
- R4: In long mode, a level held for DIG_WIN or more samples is passed through. The output pulse is as wide as the input pulse, and no output pulse is shorter than the active window.
- R5: In long mode, an output edge occurs exactly DIG_LAT clock edges (default 66) after the first rising clock edge at which the new input level is present.
- R6: In short mode (filt_dig_i low at reset), the window is FAST_WIN samples (default 16) and the latency is FAST_LAT edges (default 40). The same suppression and pass rules apply as in long mode.
- R7: Falling edges (on to off) are filtered and delayed exactly as rising edges are.
- R8: The two channels are independent. An edge or a pulse on one input never changes the other output.
- R9: filt_dig_i is captured on clock edges while rst_ni is low and on the first edge after release. Later changes to filt_dig_i do not change the window or the latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| filt_dig_i | input | 1 | Mode select, captured at reset: 1 = long window, 0 = short window |
| top_in_i | input | 1 | Raw upper-switch command (1 = on) |
| bot_in_i | input | 1 | Raw lower-switch command (1 = on) |
| top_on_o | output | 1 | Filtered upper-switch command |
| bot_on_o | output | 1 | Filtered lower-switch command |

## Verification
The bench numbers each clock edge from the first edge that samples an input level. A change that is first present at edge k, and that holds long enough, is due at the outputs just after edge k+DIG_LAT, or after edge k+FAST_LAT in short mode. The bench drives inputs on falling edges and also samples outputs on falling edges. Directed latency checks read the old value one edge before that point and the new value at it. A bench model records the raw edge at which each run of equal samples reaches the window length. It then predicts each output from that record, shifted by latency minus window plus one edges, and compares the prediction with the real output on every cycle during the random phases.

// File: rtl/spf_pkg.sv
package spf_pkg;

  typedef enum logic {
    SPF_SHORT = 1'b0,
    SPF_LONG  = 1'b1
  } spf_mode_e;

  // delay stages left after sync (2) minus one overlap and the window
  function automatic int spf_stages(int lat, int win);
    return lat - win - 1;
  endfunction

endpackage

// File: rtl/spf_sync.sv
module spf_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;

endmodule

// File: rtl/spf_persist.sv
module spf_persist #(
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] win_m1_i,
  input  logic          d_i,
  output logic          q_o
);

  logic [CW-1:0] cnt_q;
  logic          state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      state_q <= 1'b0;
    end else if (d_i == state_q) begin
      cnt_q <= '0;
    end else if (cnt_q == win_m1_i) begin
      state_q <= d_i;
      cnt_q   <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign q_o = state_q;

endmodule

// File: rtl/spf_delay.sv
module spf_delay #(
  parameter int LONG_D  = 34,
  parameter int SHORT_D = 23
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic long_i,
  input  logic d_i,
  output logic q_o
);

  localparam int MAXD = (LONG_D > SHORT_D) ? LONG_D : SHORT_D;

  logic [MAXD-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= (pipe_q << 1) | MAXD'(d_i);
  end

  assign q_o = long_i ? pipe_q[LONG_D-1] : pipe_q[SHORT_D-1];

endmodule

// File: rtl/spf_two_ch.sv
module spf_two_ch
  import spf_pkg::*;
#(
  parameter int DIG_WIN  = 31,
  parameter int DIG_LAT  = 66,
  parameter int FAST_WIN = 16,
  parameter int FAST_LAT = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic filt_dig_i,
  input  logic top_in_i,
  input  logic bot_in_i,
  output logic top_on_o,
  output logic bot_on_o
);

  localparam int NCH     = 2;
  localparam int MAX_WIN = (DIG_WIN > FAST_WIN) ? DIG_WIN : FAST_WIN;
  localparam int CW      = $clog2(MAX_WIN + 1);
  localparam int DIG_D   = spf_stages(DIG_LAT, DIG_WIN);
  localparam int FAST_D  = spf_stages(FAST_LAT, FAST_WIN);

  logic          run_q;
  spf_mode_e     mode_q;
  logic [CW-1:0] win_m1;
  logic [NCH-1:0] raw_w, sync_w, filt_w, on_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= 1'b1;
  end

  // mode follows the pin only until the first edge out of reset
  always_ff @(posedge clk_i) begin
    if (!run_q) mode_q <= spf_mode_e'(filt_dig_i);
  end

  always_comb begin
    win_m1 = (mode_q == SPF_LONG) ? CW'(DIG_WIN - 1) : CW'(FAST_WIN - 1);
  end

  assign raw_w = {bot_in_i, top_in_i};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    spf_sync u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw_w[c]),
      .q_o   (sync_w[c])
    );

    spf_persist #(.CW(CW)) u_persist (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .win_m1_i(win_m1),
      .d_i     (sync_w[c]),
      .q_o     (filt_w[c])
    );

    spf_delay #(.LONG_D(DIG_D), .SHORT_D(FAST_D)) u_delay (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .long_i(mode_q == SPF_LONG),
      .d_i   (filt_w[c]),
      .q_o   (on_w[c])
    );
  end

  assign top_on_o = on_w[0];
  assign bot_on_o = on_w[1];

endmodule

// File: rtl/spf_two_ch_chk.sv
module spf_two_ch_chk #(
  parameter int DIG_WIN  = 31,
  parameter int DIG_LAT  = 66,
  parameter int FAST_WIN = 16,
  parameter int FAST_LAT = 40,
  parameter int NCH      = 2
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           mode_i,
  input logic [NCH-1:0] sync_i,
  input logic [NCH-1:0] filt_i,
  input logic [NCH-1:0] out_i
);

  localparam int GMAX = DIG_LAT + FAST_LAT;
  localparam int GW   = $clog2(GMAX + 1);

  logic [GW-1:0] win_cur;
  assign win_cur = mode_i ? GW'(DIG_WIN) : GW'(FAST_WIN);

  // R1
  reset_low_chk: assert property (@(posedge clk_i) !rst_ni |=> out_i == '0);

  // R9
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(rst_ni, 2) |-> $stable(mode_i));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    logic          prev_q;
    logic [GW-1:0] gap_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q <= 1'b0;
        gap_q  <= '0;
      end else begin
        prev_q <= out_i[c];
        if (out_i[c] != prev_q)       gap_q <= GW'(1);
        else if (gap_q != GW'(GMAX))  gap_q <= gap_q + 1'b1;
      end
    end

    // R3
    persist_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      filt_i[c] != $past(filt_i[c]) |-> filt_i[c] == $past(sync_i[c]));

    // R4
    min_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_i[c] != prev_q |-> gap_q >= win_cur);
  end

endmodule

bind spf_two_ch spf_two_ch_chk #(
  .DIG_WIN (DIG_WIN),
  .DIG_LAT (DIG_LAT),
  .FAST_WIN(FAST_WIN),
  .FAST_LAT(FAST_LAT),
  .NCH     (NCH)
) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .mode_i(mode_q),
  .sync_i(sync_w),
  .filt_i(filt_w),
  .out_i (on_w)
);

// File: tb/spf_two_ch_bench.sv
module spf_two_ch_bench;

  localparam int DIG_WIN  = 31;
  localparam int DIG_LAT  = 66;
  localparam int FAST_WIN = 16;
  localparam int FAST_LAT = 40;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_ni = 1'b0;
  logic filt_dig = 1'b1;
  logic top_in = 1'b0;
  logic bot_in = 1'b0;
  logic top_on, bot_on;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int win_x  = DIG_WIN;
  int lat_x  = DIG_LAT;

  spf_two_ch #(
    .DIG_WIN(DIG_WIN), .DIG_LAT(DIG_LAT), .FAST_WIN(FAST_WIN), .FAST_LAT(FAST_LAT)
  ) u_spf_two_ch (
    .clk_i(clk), .rst_ni(rst_ni), .filt_dig_i(filt_dig),
    .top_in_i(top_in), .bot_in_i(bot_in),
    .top_on_o(top_on), .bot_on_o(bot_on)
  );

  task automatic chk(string req, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%b exp=%b t=%0t", req, got, exp, $time);
    end
  endtask

  // model: raw sample history, filtered level per raw edge
  bit fm [2][256];
  int run_len [2];
  bit fcur [2];
  int ecnt = 0;

  always @(posedge clk) begin
    if (!rst_ni) begin
      ecnt = 0;
      for (int c = 0; c < 2; c++) begin
        run_len[c] = 0;
        fcur[c]    = 1'b0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        bit hv;
        hv = (c == 0) ? top_in : bot_in;
        if (hv != fcur[c]) begin
          run_len[c]++;
          if (run_len[c] == win_x) begin
            fcur[c]    = hv;
            run_len[c] = 0;
          end
        end else begin
          run_len[c] = 0;
        end
        fm[c][ecnt % 256] = fcur[c];
      end
      ecnt++;
    end
  end

  // R2: every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_ni && !done && ecnt > 0) begin
      for (int c = 0; c < 2; c++) begin
        int  idx;
        bit  ev;
        idx = ecnt - 1 - (lat_x - win_x + 1);
        ev  = (idx >= 0) ? fm[c][idx % 256] : 1'b0;
        chk("R2 model", (c == 0) ? top_on : bot_on, ev);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(bit long_mode);
    @(negedge clk);
    rst_ni   = 1'b0;
    filt_dig = long_mode;
    top_in   = 1'b0;
    bot_in   = 1'b0;
    win_x    = long_mode ? DIG_WIN : FAST_WIN;
    lat_x    = long_mode ? DIG_LAT : FAST_LAT;
    step(4);
    chk("R1 top in reset", top_on, 1'b0);
    chk("R1 bot in reset", bot_on, 1'b0);
    rst_ni = 1'b1;
    step(1);
    chk("R1 top after release", top_on, 1'b0);
  endtask

  task automatic directed(string lat_tag, string win_tag);
    int w, l;
    bit seen;
    w = win_x;
    l = lat_x;
    // rising edge latency, other channel untouched
    top_in = 1'b1;
    step(l);
    chk({lat_tag, " rise early"}, top_on, 1'b0);
    step(1);
    chk({lat_tag, " rise due"}, top_on, 1'b1);
    chk("R8 bot quiet", bot_on, 1'b0);
    // R8: bot edge while top held
    bot_in = 1'b1;
    step(l);
    chk("R8 bot early", bot_on, 1'b0);
    step(1);
    chk("R8 bot due", bot_on, 1'b1);
    chk("R8 top held", top_on, 1'b1);
    // R7: falling edge latency
    top_in = 1'b0;
    step(l);
    chk("R7 fall early", top_on, 1'b1);
    step(1);
    chk("R7 fall due", top_on, 1'b0);
    step(l + 5);
    // pulses one sample short of the window, both polarities
    top_in = 1'b1;
    bot_in = 1'b0;
    step(w - 1);
    top_in = 1'b0;
    bot_in = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < l + w; i++) begin
      step(1);
      if (top_on !== 1'b0 || bot_on !== 1'b1) seen = 1'b1;
    end
    chk({win_tag, " short pulse blocked"}, seen, 1'b0);
    // pulse exactly one window long
    top_in = 1'b1;
    step(w);
    top_in = 1'b0;
    step(l - w + 1);
    chk({win_tag, " window pulse start"}, top_on, 1'b1);
    step(w - 1);
    chk({win_tag, " window pulse end"}, top_on, 1'b1);
    step(1);
    chk({win_tag, " window pulse width"}, top_on, 1'b0);
    bot_in = 1'b0;
    step(l + 5);
  endtask

  task automatic random_phase(int ncyc);
    int hold_t, hold_b;
    hold_t = 0;
    hold_b = 0;
    for (int i = 0; i < ncyc; i++) begin
      if (hold_t == 0) begin
        top_in = ~top_in;
        hold_t = $urandom_range(2 * win_x, 1);
      end else hold_t--;
      if (hold_b == 0) begin
        bot_in = ~bot_in;
        hold_b = $urandom_range(2 * win_x, 1);
      end else hold_b--;
      step(1);
    end
    top_in = 1'b0;
    bot_in = 1'b0;
    step(lat_x + 5);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    do_reset(1'b1);
    directed("R5", "R3");
    chk("R4 quiet after window pulse", top_on, 1'b0);
    // R9: pin change after reset must not alter latency
    filt_dig = 1'b0;
    step(lat_x + 5);
    top_in = 1'b1;
    step(DIG_LAT);
    chk("R9 long latency kept early", top_on, 1'b0);
    step(1);
    chk("R9 long latency kept due", top_on, 1'b1);
    top_in = 1'b0;
    step(DIG_LAT + 5);
    random_phase(3000);
    do_reset(1'b0);
    directed("R6", "R6");
    random_phase(2000);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule